// File: doc/BRIEF.md
# Dual-Output Banked Interrupt Controller

This controller gathers 224 interrupt inputs, 32 to a bank across 7 banks, and steers each one to one of two interrupt output lines. Software configures each source through a 32-bit register port. A source can detect edges or levels, can be active-high or active-low, and can be enabled or blocked. Edge events are held in a latch until software clears them by writing ones to a clear array.

For each output, software can read a masked-pending view. A summary word shows, for each output, which banks hold at least one pending, enabled source. An interrupt handler reads the summary first, then reads the one bank word it flags, so it finds the highest pending source in two reads. Register space is split into two regions, chosen by the `reg_region` pin. Region 0 holds configuration. Region 1 holds clearing, the pending views and the summary.

Top module: `dual_route_intc`

## Requirements
- R1: After reset every configuration bit (type, polarity, route, enable) is 0, every latched edge is cleared, both outputs are low, and all readable words return 0.
- R2: Region 0 holds four arrays of 7 words each, at the byte offsets given here. Type is at 0x00, polarity at 0x1C, route at 0x38 and enable at 0x54. Source s sits in word s/32 at bit s%32. Each word reads back the value last written to it, and a write touches only the word it addresses.
- R3: A source whose type bit is 0 is level-detected. It shows as pending for as long as its input, after synchronisation and polarity adjustment, is asserted. A polarity bit of 1 makes a low input the asserted state.
- R4: A source whose type bit is 1 latches an edge. With polarity 0 the edge is a rise, and with polarity 1 it is a fall. The latch holds after the input returns, and the opposite edge does not set it.
- R5: A write to the region 1 clear array (words 0 to 6, offset 0x00) clears the latched edge of every source whose bit is 1. Bits written as 0 have no effect. The clear words read as 0.
- R6: An enable bit of 0 removes the source from both pending views, the summary and the outputs. An edge it has already latched is kept.
- R7: A route bit of 1 sends the source to output 0, whose pending view sits at region 1 offset 0x38. A route bit of 0 sends it to output 1, whose view sits at offset 0x1C. A source never appears in both views.
- R8: The region 1 word at 0x7C is the summary. Bit b (for b from 0 to 6) is set when bank b has a pending source on output 1. Bit 8+b is set when bank b has a pending source on output 0. All other bits are 0.
- R9: Each output is the OR of its pending view, registered once. It rises one clock after a pending bit appears, and it falls one clock after the view empties.
- R10: Each input passes through two synchroniser flops. An input changed before clock edge k shows in the pending view after edge k+1, and on the output after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_region | input | 1 | Register region select (0 config, 1 status/clear) |
| reg_addr | input | 7 | Byte offset within the region; bits [1:0] ignored |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word, combinational |
| irq_in | input | 224 | Interrupt source inputs |
| irq_out0 | output | 1 | Output line 0 (sources with route bit 1) |
| irq_out1 | output | 1 | Output line 1 (sources with route bit 0) |

## Verification
The hardest state to reach is a falling-edge latch. It needs a source configured as an edge source with polarity 1, an input that first rises without setting the latch, and then a fall that does set it. Flipping the polarity bit while the input is low creates a spurious adjusted rise. The bench therefore clears that latch with the clear array before it drives the real sequence, so that the latch which remains can only come from the fall. The bench then keeps the latched edge alive and removes the enable bit, to show that masking hides the latch without destroying it.

// File: rtl/dual_route_intc.sv
module dual_route_intc #(
  parameter int NUM_BANK = 7,
  parameter int BANK_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_region,
  input  logic [6:0]                   reg_addr,
  input  logic                         reg_wr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic [NUM_BANK*BANK_W-1:0]   irq_in,
  output logic                         irq_out0,
  output logic                         irq_out1
);
  localparam int NSRC     = NUM_BANK * BANK_W;
  localparam int SUM_WORD = 31;
  localparam int SUM0_LSB = 8;

  logic [NSRC-1:0] type_q, pol_q, route_q, en_q, edge_q;
  logic [NSRC-1:0] s1_q, s2_q, prev_q;
  logic [NSRC-1:0] adj, pend, view0, view1, clr;
  logic [NUM_BANK-1:0] sum0, sum1;
  logic [4:0] word;

  assign word  = reg_addr[6:2];
  assign adj   = s2_q ^ pol_q;
  assign pend  = (type_q & edge_q) | (~type_q & adj);
  assign view0 = pend & en_q & route_q;
  assign view1 = pend & en_q & ~route_q;

  always_comb begin
    clr = '0;
    if (reg_wr && reg_region)
      for (int b = 0; b < NUM_BANK; b++)
        if (int'(word) == b) clr[b*BANK_W +: BANK_W] = reg_wdata[BANK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q  <= '0;
      pol_q   <= '0;
      route_q <= '0;
      en_q    <= '0;
    end else if (reg_wr && !reg_region) begin
      for (int b = 0; b < NUM_BANK; b++) begin
        if (int'(word) == b)              type_q[b*BANK_W +: BANK_W]  <= reg_wdata[BANK_W-1:0];
        if (int'(word) == b + NUM_BANK)   pol_q[b*BANK_W +: BANK_W]   <= reg_wdata[BANK_W-1:0];
        if (int'(word) == b + 2*NUM_BANK) route_q[b*BANK_W +: BANK_W] <= reg_wdata[BANK_W-1:0];
        if (int'(word) == b + 3*NUM_BANK) en_q[b*BANK_W +: BANK_W]    <= reg_wdata[BANK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q     <= '0;
      s2_q     <= '0;
      prev_q   <= '0;
      edge_q   <= '0;
      irq_out0 <= 1'b0;
      irq_out1 <= 1'b0;
    end else begin
      s1_q     <= irq_in;
      s2_q     <= s1_q;
      prev_q   <= adj;
      edge_q   <= (edge_q & ~clr) | (type_q & adj & ~prev_q);
      irq_out0 <= |view0;
      irq_out1 <= |view1;
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANK; b++) begin
      sum0[b] = |view0[b*BANK_W +: BANK_W];
      sum1[b] = |view1[b*BANK_W +: BANK_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (!reg_region) begin
        if (int'(word) == b)              reg_rdata[BANK_W-1:0] = type_q[b*BANK_W +: BANK_W];
        if (int'(word) == b + NUM_BANK)   reg_rdata[BANK_W-1:0] = pol_q[b*BANK_W +: BANK_W];
        if (int'(word) == b + 2*NUM_BANK) reg_rdata[BANK_W-1:0] = route_q[b*BANK_W +: BANK_W];
        if (int'(word) == b + 3*NUM_BANK) reg_rdata[BANK_W-1:0] = en_q[b*BANK_W +: BANK_W];
      end else begin
        if (int'(word) == b + NUM_BANK)   reg_rdata[BANK_W-1:0] = view1[b*BANK_W +: BANK_W];
        if (int'(word) == b + 2*NUM_BANK) reg_rdata[BANK_W-1:0] = view0[b*BANK_W +: BANK_W];
      end
    end
    if (reg_region && int'(word) == SUM_WORD) begin
      reg_rdata[NUM_BANK-1:0]          = sum1;
      reg_rdata[SUM0_LSB +: NUM_BANK]  = sum0;
    end
  end
endmodule

module dual_route_intc_chk #(
  parameter int NSRC = 224
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_out0,
  input logic            irq_out1,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] view0,
  input logic [NSRC-1:0] view1,
  input logic [NSRC-1:0] edge_q,
  input logic [NSRC-1:0] clr
);
  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> (!irq_out0 && !irq_out1));
  // R9
  out0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (view0 != '0) |=> irq_out0);
  // R9
  out1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (view1 == '0) |=> !irq_out1);
  // R7
  route_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (view0 & view1) == '0);
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> (($past(edge_q) & ~edge_q) == '0));
endmodule

bind dual_route_intc dual_route_intc_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out0(irq_out0), .irq_out1(irq_out1),
  .en_q(en_q), .view0(view0), .view1(view1), .edge_q(edge_q), .clr(clr)
);

// File: tb/dual_route_intc_bench.sv
module dual_route_intc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_region = 1'b0;
  logic [6:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [223:0] src = '0;
  logic         irq_out0, irq_out1;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dual_route_intc u_dual_route_intc (
    .clk(clk), .rst_n(rst_n), .reg_region(reg_region), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(src), .irq_out0(irq_out0), .irq_out1(irq_out1)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic rg, input int w, input logic [31:0] d);
    @(negedge clk);
    reg_region = rg; reg_addr = 7'(w * 4); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic rg, input int w, output logic [31:0] d);
    @(negedge clk);
    reg_region = rg; reg_addr = 7'(w * 4);
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 out0", {31'b0, irq_out0}, 0);
    check("R1 out1", {31'b0, irq_out1}, 0);
    rd(0, 0, v);  check("R1 type", v, 0);
    rd(0, 24, v); check("R1 enable", v, 0);
    rd(1, 31, v); check("R1 summary", v, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(0, 3, 32'hA5A5_0001);  wr(0, 10, 32'h1234_5678);
    wr(0, 17, 32'h0F0F_F0F0); wr(0, 24, 32'h8000_0001);
    rd(0, 3, v);  check("R2 type word3", v, 32'hA5A5_0001);
    rd(0, 10, v); check("R2 pol word3", v, 32'h1234_5678);
    rd(0, 17, v); check("R2 route word3", v, 32'h0F0F_F0F0);
    rd(0, 24, v); check("R2 enable word3", v, 32'h8000_0001);
    rd(0, 4, v);  check("R2 neighbour untouched", v, 0);
    wr(0, 3, 0); wr(0, 10, 0); wr(0, 17, 0); wr(0, 24, 0);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    wr(0, 14, 32'h20); wr(0, 21, 32'h20);
    @(negedge clk);
    src[5] = 1'b1;
    @(negedge clk);
    reg_region = 1; reg_addr = 7'(14 * 4);
    #1 check("R10 not yet pending", reg_rdata, 0);
    @(negedge clk);
    #1 check("R10 pending after 2 edges", reg_rdata, 32'h20);
    check("R10 out0 still low", {31'b0, irq_out0}, 0);
    @(negedge clk);
    check("R9 out0 high", {31'b0, irq_out0}, 1);
    check("R7 out1 unused", {31'b0, irq_out1}, 0);
    rd(1, 7, v); check("R7 view1 empty", v, 0);
  endtask

  task automatic t_level_pol;
    logic [31:0] v;
    wr(0, 7, 32'h20);
    rd(1, 14, v); check("R3 active-low, input high", v, 0);
    idle(2); check("R9 out0 falls", {31'b0, irq_out0}, 0);
    src[5] = 1'b0; idle(4);
    rd(1, 14, v); check("R3 active-low, input low", v, 32'h20);
    check("R3 out0", {31'b0, irq_out0}, 1);
    wr(0, 7, 0); wr(0, 21, 0); wr(0, 14, 0);
    idle(2);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(0, 1, 32'h100); wr(0, 22, 32'h100); idle(4);
    rd(1, 8, v); check("R4 no edge yet", v, 0);
    src[40] = 1'b1; idle(4);
    rd(1, 8, v); check("R4 rise latched", v, 32'h100);
    check("R7 out1", {31'b0, irq_out1}, 1);
    src[40] = 1'b0; idle(4);
    rd(1, 8, v); check("R4 held after input returns", v, 32'h100);
    wr(1, 1, 32'hFFFF_FEFF); idle(2);
    rd(1, 8, v); check("R5 zero bit no effect", v, 32'h100);
    rd(1, 1, v); check("R5 clear word reads 0", v, 0);
    wr(1, 1, 32'h100);
    rd(1, 8, v); check("R5 cleared", v, 0);
    idle(2); check("R9 out1 falls", {31'b0, irq_out1}, 0);
    wr(0, 8, 32'h100); idle(3);
    wr(1, 1, 32'h100); idle(3);
    rd(1, 8, v); check("R4 falling mode clean", v, 0);
    src[40] = 1'b1; idle(4);
    rd(1, 8, v); check("R4 rise ignored in falling mode", v, 0);
    src[40] = 1'b0; idle(4);
    rd(1, 8, v); check("R4 fall latched", v, 32'h100);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(0, 22, 0);
    rd(1, 8, v); check("R6 masked view", v, 0);
    rd(1, 31, v); check("R6 masked summary", v, 0);
    idle(2); check("R6 out1 low", {31'b0, irq_out1}, 0);
    wr(0, 22, 32'h100);
    rd(1, 8, v); check("R6 latch kept", v, 32'h100);
  endtask

  task automatic t_summary;
    logic [31:0] v;
    wr(0, 20, 32'h100); wr(0, 27, 32'h100);
    src[200] = 1'b1; idle(4);
    rd(1, 20, v); check("R7 view0 bank6", v, 32'h100);
    rd(1, 31, v); check("R8 summary both", v, 32'h0000_4002);
    check("R9 out0", {31'b0, irq_out0}, 1);
    check("R9 out1", {31'b0, irq_out1}, 1);
    wr(0, 20, 0);
    rd(1, 13, v); check("R7 rerouted view1", v, 32'h100);
    rd(1, 20, v); check("R7 view0 empty", v, 0);
    rd(1, 31, v); check("R8 summary out1 only", v, 32'h0000_0042);
    idle(2); check("R9 out0 falls", {31'b0, irq_out0}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_regmap;
    t_latency;
    t_level_pol;
    t_edge;
    t_mask;
    t_summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule